// File: doc/BRIEF.md
# Three-channel reloading down-counter timer

This block is a memory-mapped timer with `NCH` independent 32-bit channels (three by default). Each channel owns a down-counter, a reload value and a small control register. A channel counts down once per tick of its own prescaler, which divides the peripheral clock by 4, 16, 64, 256 or 1024. When the counter passes zero it is refilled from the reload value, and a sticky underflow flag is set. The flag can drive that channel's interrupt line.

A single byte-wide run register holds one start bit per channel, so software starts and stops every channel from one place. The host reaches all registers over a simple synchronous bus. That bus has a byte address, a 32-bit write data word, separate write and read strobes, and an access size of byte, halfword or word. Read data comes back one clock after the read strobe.

Software programs a channel while it is stopped: it writes the counter and the reload value, then picks the divider and the interrupt enable. It then sets the run bit. An interrupt is acknowledged by writing the control register with the flag bit at zero.

Top module: `dnt_timer`

## Requirements
- R1: After reset every run bit, divider field, interrupt enable and underflow flag is 0, every counter and reload value reads 0xFFFFFFFF, and every interrupt line is low.
- R2: The run register sits at byte address 4. Bit n set runs channel n and bit n clear stops it. Bits at and above NCH read as zero.
- R3: Channel n occupies byte addresses 8+12n (reload value, 32 bits), 12+12n (counter, 32 bits) and 16+12n (control). Each register reads back what was last written to it.
- R4: Control bits [2:0] select the tick as the clock divided by 4, 16, 64, 256 or 1024, for codes 0, 1, 2, 3 and 4. Codes 5, 6 and 7 give no ticks, so the counter holds.
- R5: A running channel decrements its counter by one per tick. A stopped channel's counter does not change unless it is written.
- R6: A tick that finds the counter at 0 loads the counter from the reload value and sets the underflow flag, control bit 8. With a reload value of r, underflows therefore repeat every r+1 ticks.
- R7: A channel's interrupt line is high exactly while its flag (control bit 8) and its interrupt enable (control bit 5) are both 1.
- R8: A halfword or word write to the control register with bit 8 at 0 clears the flag. With bit 8 at 1 the flag is left as it is. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: A counter write takes effect at the clock edge of the write, even while the channel runs. It overrides a decrement or reload in that same cycle.
- R10: Control bits other than [2:0], 5 and 8 are not stored and read as zero.
- R11: A channel's prescaler restarts whenever its run bit goes from 0 to 1. The first decrement therefore lands exactly one full divider period after the start write's clock edge.
- R12: Size code 0 (byte), 1 (halfword) and 2 or 3 (word) select a write of the low 8, 16 or 32 bits of the addressed register. A byte write cannot reach control bit 8. Read data appears on the cycle after the read strobe, masked to the access size, and holds until the next read. Unmapped addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data, low bytes used for narrow writes |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NCH | Per-channel underflow interrupt |

## Verification
The bench builds the block with its defaults: three channels and an 8-bit address. This means every channel offset in the map and the run bits above the channel count are reachable. Every channel is swept through all five divider codes. For each code, the counter is read on the exact edge of the first tick and on the edge just after it, and again after the channel is stopped. The expected count is derived from the cycle distance to the start edge. Small counter and reload values bring underflow, reload, collisions between a clearing write and an underflow, and collisions between a counter write and a tick within a few dozen cycles.

// File: rtl/dnt_pkg.sv
package dnt_pkg;

  localparam int DW          = 32;
  localparam int PSC_SEL_W   = 3;
  localparam int PSC_MAX_SEL = 4;
  localparam int PSC_W       = 2 * PSC_MAX_SEL + 2;

  localparam int RUN_OFF     = 4;
  localparam int CH_BASE     = 8;
  localparam int CH_STRIDE   = 12;
  localparam int OFF_RELOAD  = 0;
  localparam int OFF_COUNT   = 4;
  localparam int OFF_CTL     = 8;

  localparam int CTL_IE_BIT   = 5;
  localparam int CTL_FLAG_BIT = 8;

  typedef struct packed {
    logic                 flag;
    logic                 ie;
    logic [PSC_SEL_W-1:0] psc;
  } ctl_t;

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    logic [DW-1:0] m;
    case (sz)
      2'd0:    m = DW'(32'h0000_00FF);
      2'd1:    m = DW'(32'h0000_FFFF);
      default: m = {DW{1'b1}};
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] ctl_pack(input ctl_t c);
    logic [DW-1:0] r;
    r                = '0;
    r[PSC_SEL_W-1:0] = c.psc;
    r[CTL_IE_BIT]    = c.ie;
    r[CTL_FLAG_BIT]  = c.flag;
    return r;
  endfunction

endpackage

// File: rtl/dnt_prescaler.sv
module dnt_prescaler
  import dnt_pkg::*;
#(
  parameter int SEL_W   = PSC_SEL_W,
  parameter int MAX_SEL = PSC_MAX_SEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int CNT_W = 2 * MAX_SEL + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             sel_ok;

  always_comb begin
    sel_ok = (int'(sel) <= MAX_SEL);
    lim    = sel_ok ? CNT_W'((32'd1 << (2 * int'(sel) + 2)) - 32'd1) : '0;
    tick   = run && sel_ok && (cnt_q >= lim);
    if (!run)        cnt_d = '0;
    else if (!sel_ok) cnt_d = cnt_q;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0)); // R11

endmodule

// File: rtl/dnt_channel.sv
module dnt_channel
  import dnt_pkg::*;
#(
  parameter int CW = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rel_we,
  input  logic          cnt_we,
  input  logic          ctl_we,
  input  logic          ctl_hi_we,
  input  logic [CW-1:0] wmask,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] reload_o,
  output logic [CW-1:0] count_o,
  output ctl_t          ctl_o,
  output logic          irq_o
);

  logic [CW-1:0] reload_q, reload_d, count_q, count_d;
  ctl_t          ctl_q, ctl_d;
  logic          tick, undf, flag_clr;

  dnt_prescaler #(.SEL_W(PSC_SEL_W), .MAX_SEL(PSC_MAX_SEL)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (ctl_q.psc),
    .tick (tick)
  );

  always_comb begin
    undf     = tick && (count_q == '0);
    flag_clr = ctl_we && ctl_hi_we && !wdata[CTL_FLAG_BIT];

    reload_d = rel_we ? ((reload_q & ~wmask) | (wdata & wmask)) : reload_q;

    if (cnt_we)    count_d = (count_q & ~wmask) | (wdata & wmask);
    else if (undf) count_d = reload_q;
    else if (tick) count_d = count_q - CW'(1);
    else           count_d = count_q;

    ctl_d      = ctl_q;
    if (ctl_we) begin
      ctl_d.psc = wdata[PSC_SEL_W-1:0];
      ctl_d.ie  = wdata[CTL_IE_BIT];
    end
    if (undf)          ctl_d.flag = 1'b1;
    else if (flag_clr) ctl_d.flag = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= {CW{1'b1}};
      count_q  <= {CW{1'b1}};
      ctl_q    <= '0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      ctl_q    <= ctl_d;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctl_o    = ctl_q;
  assign irq_o    = ctl_q.flag & ctl_q.ie;

  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (undf && !cnt_we) |=> ((count_q == $past(reload_q)) && ctl_q.flag)); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.flag) |-> $past(undf)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !(ctl_we && ctl_hi_we)) |=> ctl_q.flag); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(count_q)); // R5
  AST_COUNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && (wmask == {CW{1'b1}})) |=> (count_q == $past(wdata))); // R9

endmodule

// File: rtl/dnt_regdec.sv
module dnt_regdec
  import dnt_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 8,
  parameter int CW  = DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic                   we,
  input  logic                   re,
  input  logic [1:0]             size,
  input  logic [NCH-1:0]         run_i,
  input  logic [NCH-1:0][CW-1:0] rel_i,
  input  logic [NCH-1:0][CW-1:0] cnt_i,
  input  logic [NCH-1:0][CW-1:0] ctl_i,
  output logic                   run_we,
  output logic [NCH-1:0]         rel_we,
  output logic [NCH-1:0]         cnt_we,
  output logic [NCH-1:0]         ctl_we,
  output logic                   ctl_hi_we,
  output logic [CW-1:0]          wmask,
  output logic [CW-1:0]          rdata
);

  logic [CW-1:0] rsel, rdata_q, rdata_d;

  assign run_we    = we && (addr == AW'(RUN_OFF));
  assign ctl_hi_we = (size != 2'd0);
  assign wmask     = lane_mask(size);

  for (genvar n = 0; n < NCH; n++) begin : g_wdec
    assign rel_we[n] = we && (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_RELOAD));
    assign cnt_we[n] = we && (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_COUNT));
    assign ctl_we[n] = we && (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_CTL));
  end

  always_comb begin
    rsel = '0;
    if (addr == AW'(RUN_OFF)) rsel = CW'(run_i);
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_RELOAD)) rsel = rel_i[n];
      if (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_COUNT))  rsel = cnt_i[n];
      if (addr == AW'(CH_BASE + CH_STRIDE * n + OFF_CTL))    rsel = ctl_i[n];
    end
    rdata_d = re ? (rsel & wmask) : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (size == 2'd0)) |=> (rdata[CW-1:8] == '0)); // R12
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_we, rel_we, cnt_we, ctl_we})); // R3

endmodule

// File: rtl/dnt_timer.sv
module dnt_timer
  import dnt_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [1:0]     bus_size,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq
);

  localparam int CW = DW;

  logic [NCH-1:0]         run_q, run_d;
  logic                   run_we, ctl_hi_we;
  logic [NCH-1:0]         rel_we, cnt_we, ctl_we;
  logic [CW-1:0]          wmask;
  logic [NCH-1:0][CW-1:0] rel_bus, cnt_bus, ctl_bus;

  dnt_regdec #(.NCH(NCH), .AW(AW), .CW(CW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .re       (bus_re),
    .size     (bus_size),
    .run_i    (run_q),
    .rel_i    (rel_bus),
    .cnt_i    (cnt_bus),
    .ctl_i    (ctl_bus),
    .run_we   (run_we),
    .rel_we   (rel_we),
    .cnt_we   (cnt_we),
    .ctl_we   (ctl_we),
    .ctl_hi_we(ctl_hi_we),
    .wmask    (wmask),
    .rdata    (bus_rdata)
  );

  always_comb begin
    run_d = run_we ? bus_wdata[NCH-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ctl_t ctl_s;

    dnt_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[n]),
      .rel_we   (rel_we[n]),
      .cnt_we   (cnt_we[n]),
      .ctl_we   (ctl_we[n]),
      .ctl_hi_we(ctl_hi_we),
      .wmask    (wmask),
      .wdata    (bus_wdata),
      .reload_o (rel_bus[n]),
      .count_o  (cnt_bus[n]),
      .ctl_o    (ctl_s),
      .irq_o    (irq[n])
    );

    assign ctl_bus[n] = ctl_pack(ctl_s);
  end

  AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    run_we |=> (run_q == $past(bus_wdata[NCH-1:0]))); // R2
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_we |=> $stable(run_q)); // R2

endmodule

// File: tb/dnt_timer_bench.sv
module dnt_timer_bench;

  localparam int NCH        = 3;
  localparam int AW         = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;
  localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]     bus_size = 2'd2;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] irq;

  int cyc = 0, n_chk = 0, n_fail = 0, last_edge = 0;
  logic [31:0] rv;

  dnt_timer #(.NCH(NCH), .AW(AW)) u_dnt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int a_rel(int n); return 8 + 12 * n; endfunction
  function automatic int a_cnt(int n); return 12 + 12 * n; endfunction
  function automatic int a_ctl(int n); return 16 + 12 * n; endfunction

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > WDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      summary_and_end();
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    last_edge = cyc + 1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_size = sz; bus_re = 1'b1;
    last_edge = cyc + 1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  // Position so that the next wr/rd lands on edge t.
  task automatic aim(input int t);
    while (cyc + 2 < t) @(negedge clk);
  endtask

  initial begin
    int e0, es, div, eu;
    logic [31:0] exp_v;

    repeat (3) @(negedge clk);
    check("R1", "irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;

    // R1 reset state
    rd(4, SW, rv); check("R1", "run reg", rv, 32'h0);
    for (int n = 0; n < NCH; n++) begin
      rd(a_rel(n), SW, rv); check("R1", "reload", rv, 32'hFFFF_FFFF);
      rd(a_cnt(n), SW, rv); check("R1", "count", rv, 32'hFFFF_FFFF);
      rd(a_ctl(n), SW, rv); check("R1", "ctl", rv, 32'h0);
    end

    // R3 address map, distinct per channel
    for (int n = 0; n < NCH; n++) begin
      wr(a_rel(n), 32'h1000 + 32'(n), SW);
      wr(a_cnt(n), 32'h2000 + 32'(n), SW);
    end
    for (int n = 0; n < NCH; n++) begin
      rd(a_rel(n), SW, rv); check("R3", "reload map", rv, 32'h1000 + 32'(n));
      rd(a_cnt(n), SW, rv); check("R3", "count map", rv, 32'h2000 + 32'(n));
    end

    // R12 access sizes and unmapped space
    wr(a_rel(0), 32'hFFFF_FFAB, SB);
    rd(a_rel(0), SW, rv); check("R12", "byte write", rv, 32'h0000_10AB);
    wr(a_rel(0), 32'h1234_CDEF, SH);
    rd(a_rel(0), SW, rv); check("R12", "half write", rv, 32'h0000_CDEF);
    rd(a_rel(0), SB, rv); check("R12", "byte read", rv, 32'h0000_00EF);
    rd(a_rel(0), SH, rv); check("R12", "half read", rv, 32'h0000_CDEF);
    wr(44, 32'hDEAD_BEEF, SW);
    rd(44, SW, rv); check("R12", "unmapped read", rv, 32'h0);
    rd(0, SW, rv); check("R12", "addr 0 read", rv, 32'h0);
    for (int n = 0; n < NCH; n++) begin
      rd(a_cnt(n), SW, rv); check("R12", "unmapped write ignored", rv, 32'h2000 + 32'(n));
    end

    // R10 unused control bits
    wr(a_ctl(0), 32'hFFFF_FEFF, SW);
    rd(a_ctl(0), SW, rv); check("R10", "ctl unused bits", rv, 32'h0000_0027);
    wr(a_ctl(0), 32'h0000_FFFF, SH);
    rd(a_ctl(0), SW, rv); check("R8", "write 1 to flag", rv, 32'h0000_0027);
    wr(a_ctl(0), 32'h0, SH);

    // R2 run register
    wr(4, 32'hFF, SB);
    rd(4, SW, rv); check("R2", "run bits above NCH", rv, 32'h7);
    wr(4, 32'h0, SB);
    rd(4, SW, rv); check("R2", "run cleared", rv, 32'h0);

    // R4 R5 R11 divider sweep over every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int e = 0; e <= 4; e++) begin
        div = 4 << (2 * e);
        wr(a_ctl(ch), 32'(e), SH);
        wr(a_cnt(ch), 32'd1000, SW);
        wr(4, 32'(1 << ch), SB); e0 = last_edge;
        aim(e0 + div);
        rd(a_cnt(ch), SW, rv); check("R11", "no tick before period", rv, 32'd1000);
        rd(a_cnt(ch), SW, rv); check("R11", "first tick at period", rv, 32'd999);
        repeat (div * 2 + 3) @(negedge clk);
        rd(a_cnt(ch), SW, rv);
        check("R4", "divided count", rv, 32'(1000 - (last_edge - 1 - e0) / div));
        wr(4, 32'h0, SB); es = last_edge;
        exp_v = 32'(1000 - (es - e0) / div);
        repeat (div + 5) @(negedge clk);
        rd(a_cnt(ch), SW, rv); check("R5", "stopped holds", rv, exp_v);
      end
    end

    // R4 codes 5..7 hold
    for (int e = 5; e <= 7; e++) begin
      wr(a_ctl(0), 32'(e), SH);
      wr(a_cnt(0), 32'd77, SW);
      wr(4, 32'h1, SB);
      repeat (40) @(negedge clk);
      rd(a_cnt(0), SW, rv); check("R4", "invalid code holds", rv, 32'd77);
      wr(4, 32'h0, SB);
    end

    // R6 R7 underflow with interrupt enabled on channel 1
    wr(a_ctl(1), 32'h20, SH);
    wr(a_rel(1), 32'd2, SW);
    wr(a_cnt(1), 32'd1, SW);
    wr(4, 32'h2, SB); e0 = last_edge;
    eu = e0 + 8;
    while (cyc < eu - 1) @(negedge clk);
    check("R7", "irq before underflow", 32'(irq), 32'h0);
    @(negedge clk);
    check("R7", "irq after underflow", 32'(irq), 32'h2);
    rd(a_cnt(1), SW, rv); check("R6", "reloaded count", rv, 32'd2);
    rd(a_ctl(1), SW, rv); check("R6", "flag set", rv, 32'h120);
    while (cyc < eu + 12) @(negedge clk);
    rd(a_cnt(1), SW, rv); check("R6", "second reload after r+1 ticks", rv, 32'd2);
    wr(4, 32'h0, SB);
    wr(a_ctl(1), 32'h20, SH);
    check("R8", "irq after ack", 32'(irq), 32'h0);
    rd(a_ctl(1), SW, rv); check("R8", "flag cleared", rv, 32'h20);

    // R7 flag without enable on channel 2
    wr(a_ctl(2), 32'h0, SH);
    wr(a_cnt(2), 32'h0, SW);
    wr(4, 32'h4, SB);
    repeat (6) @(negedge clk);
    check("R7", "no irq without enable", 32'(irq), 32'h0);
    wr(4, 32'h0, SB);
    rd(a_ctl(2), SW, rv); check("R6", "flag without enable", rv, 32'h100);
    wr(a_ctl(2), 32'h100, SH);
    rd(a_ctl(2), SW, rv); check("R8", "write 1 keeps flag", rv, 32'h100);
    wr(a_ctl(2), 32'h0, SB);
    rd(a_ctl(2), SW, rv); check("R12", "byte write misses flag", rv, 32'h100);
    wr(a_ctl(2), 32'h0, SW);
    rd(a_ctl(2), SW, rv); check("R8", "word write clears flag", rv, 32'h0);

    // R8 set beats clear in the same cycle
    wr(a_ctl(0), 32'h0, SH);
    wr(a_rel(0), 32'd5, SW);
    wr(a_cnt(0), 32'd0, SW);
    wr(4, 32'h1, SB); e0 = last_edge;
    aim(e0 + 4);
    wr(a_ctl(0), 32'h0, SH);
    check("R8", "clear aimed at underflow edge", 32'(last_edge), 32'(e0 + 4));
    rd(a_ctl(0), SW, rv); check("R8", "set wins over clear", rv, 32'h100);
    wr(4, 32'h0, SB);
    wr(a_ctl(0), 32'h0, SH);

    // R9 counter write overrides a tick in the same cycle
    wr(a_cnt(0), 32'd100, SW);
    wr(4, 32'h1, SB); e0 = last_edge;
    aim(e0 + 8);
    wr(a_cnt(0), 32'd50, SW);
    rd(a_cnt(0), SW, rv); check("R9", "write wins over tick", rv, 32'd50);
    repeat (10) @(negedge clk);
    rd(a_cnt(0), SW, rv);
    check("R9", "counts on from written value", rv, 32'(50 - ((last_edge - 1 - e0) / 4 - 2)));
    wr(4, 32'h0, SB);

    summary_and_end();
  end

endmodule